// File: doc/BRIEF.md
# Counting-Sort Readout Sequencer

This block is the back end of a counting sort. A histogram of occurrence counts, one entry per possible value, has been built in an external dual-port RAM. When the filling side lowers its frame strobe, the sequencer walks the table from the lowest address to the highest. For every address it emits the address itself as a sorted data value, once per counted occurrence. The output uses a frame strobe and a per-word valid strobe.

Reads go out through a one-cycle-latency read port. The returned counts land in a small prefetch store, so the emitter always has the next entry at hand and a run of non-empty bins streams with no idle cycles. Each entry is zeroed through the RAM's second port right after it is read, so the table is empty and ready for the next fill once the pass ends.

Top module: `cs_readout`

## Requirements
- R1: While `rst_n` is low, and right after reset, `out_valid`, `out_frame`, `ram_rd_en` and `ram_clr_en` are all 0.
- R2: A pass starts only on a high-to-low transition of `in_frame` seen while no pass is running. A rising edge starts nothing, and a falling edge during a pass has no effect on that pass.
- R3: During a pass every table address from 0 to 2^ADDR_W-1 is read exactly once, in strictly ascending order, and no read is issued outside a pass.
- R4: The emitted words are the table addresses in ascending order. Each address appears on `out_data` with `out_valid` high exactly as many times as the count read from it.
- R5: A count of 0 produces no valid word, and a count of 1 produces exactly one valid word. The largest count, 2^CNT_W-1, is emitted in full.
- R6: When consecutive table entries are all non-zero, their words come out on consecutive cycles with no gap.
- R7: `out_frame` rises in the cycle of the first valid word and stays high continuously until the table has been consumed. `out_valid` is never high without `out_frame`. When the top address holds a non-zero count, `out_frame` falls in the cycle right after the last valid word. A table of all zeros never raises `out_frame`.
- R8: One cycle after each read, `ram_clr_en` is high with `ram_clr_addr` equal to the address read, so the whole table holds zeros after a pass.
- R9: The prefetch store never accepts an entry while full. Reads are throttled against entries already held plus the one in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_frame | input | 1 | Frame strobe of the filling side; its falling edge starts a pass |
| ram_rd_en | output | 1 | Read request to the count RAM |
| ram_rd_addr | output | ADDR_W | Read address |
| ram_rd_data | input | CNT_W | Count returned one cycle after the request |
| ram_clr_en | output | 1 | Write strobe that zeroes one entry |
| ram_clr_addr | output | ADDR_W | Address of the entry being zeroed |
| out_frame | output | 1 | High across the emitted sorted sequence |
| out_valid | output | 1 | Marks a valid sorted word |
| out_data | output | ADDR_W | Sorted value |

## Verification
The bench builds the block with ADDR_W=4, CNT_W=3, PF_DEPTH=2 and registered outputs. A full sweep then takes sixteen reads, so both ends of the address range are reached in every pass. Counts saturate at 7, so a table with every bin at maximum drives a 112-word unbroken stream that exercises the prefetch throttle at its tightest point. With a store only two entries deep, runs of count-one bins test whether the store sustains one new entry per cycle. Tables with leading, interior and trailing zeros cover the empty-bin path and the frame's fall timing.

// File: rtl/cs_readout_pkg.sv
package cs_readout_pkg;

   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int occ_width(input int depth);
      return $clog2(depth + 1);
   endfunction

   function automatic int ptr_width(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/cs_readout_fetch.sv
module cs_readout_fetch #(
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 2,
   parameter int OCC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic [OCC_W-1:0]  occ,
   input  logic              pop,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              inflight,
   output logic [ADDR_W-1:0] inflight_addr,
   output logic              all_issued
);

   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   logic [ADDR_W-1:0] nxt_q;
   logic              done_q;
   logic              infl_q;
   logic [ADDR_W-1:0] infl_addr_q;
   logic              room;

   // entries held after this edge, plus the one a new read would add
   always_comb begin
      room  = (int'(occ) + int'(infl_q) - int'(pop)) < DEPTH;
      rd_en = active & ~done_q & room;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nxt_q       <= '0;
         done_q      <= 1'b1;
         infl_q      <= 1'b0;
         infl_addr_q <= '0;
      end else begin
         if (start) begin
            nxt_q  <= '0;
            done_q <= 1'b0;
         end else if (rd_en) begin
            nxt_q <= nxt_q + 1'b1;
            if (nxt_q == TOP_ADDR) done_q <= 1'b1;
         end
         infl_q <= rd_en;
         if (rd_en) infl_addr_q <= nxt_q;
      end
   end

   assign rd_addr       = nxt_q;
   assign inflight      = infl_q;
   assign inflight_addr = infl_addr_q;
   assign all_issued    = done_q;

endmodule

// File: rtl/cs_readout_store.sv
module cs_readout_store #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 8,
   parameter int DEPTH  = 2,
   parameter int OCC_W  = 2,
   parameter int PTR_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [CNT_W-1:0]  push_cnt,
   input  logic              pop,
   output logic [OCC_W-1:0]  occ,
   output logic [ADDR_W-1:0] head_addr,
   output logic [CNT_W-1:0]  head_cnt
);

   localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] addr_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q  [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [OCC_W-1:0]  occ_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[g] <= '0;
            cnt_q[g]  <= '0;
         end else if (push && wp_q == PTR_W'(g)) begin
            addr_q[g] <= push_addr;
            cnt_q[g]  <= push_cnt;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         occ_q <= '0;
      end else begin
         if (push) wp_q <= (wp_q == LAST_SLOT) ? '0 : wp_q + 1'b1;
         if (pop)  rp_q <= (rp_q == LAST_SLOT) ? '0 : rp_q + 1'b1;
         case ({push, pop})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   assign occ       = occ_q;
   assign head_addr = addr_q[rp_q];
   assign head_cnt  = cnt_q[rp_q];

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (occ_q < OCC_W'(DEPTH)) || pop);

   a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> occ_q != '0);

endmodule

// File: rtl/cs_readout_emit.sv
module cs_readout_emit #(
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              head_valid,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic [CNT_W-1:0]  head_cnt,
   input  logic              pass_end,
   output logic              pop,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_data,
   output logic              out_frame
);

   logic [CNT_W-1:0] used_q;
   logic             frame_q;
   logic             fire;
   logic             final_unit;

   always_comb begin
      fire       = head_valid & (head_cnt != '0);
      final_unit = (used_q == head_cnt - 1'b1);
      pop        = head_valid & ((head_cnt == '0) | final_unit);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q  <= '0;
         frame_q <= 1'b0;
      end else begin
         if (start)     used_q <= '0;
         else if (fire) used_q <= final_unit ? '0 : used_q + 1'b1;
         if (start || pass_end) frame_q <= 1'b0;
         else if (fire)         frame_q <= 1'b1;
      end
   end

   if (OUT_REG) begin : g_reg_out
      logic              valid_q;
      logic [ADDR_W-1:0] data_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
         end else begin
            valid_q <= fire;
            if (fire) data_q <= head_addr;
         end
      end
      assign out_valid = valid_q;
      assign out_data  = data_q;
      assign out_frame = frame_q;
   end else begin : g_comb_out
      assign out_valid = fire;
      assign out_data  = head_addr;
      assign out_frame = (frame_q & ~pass_end) | fire;
   end

   a_r5_dwell_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> used_q < head_cnt);

endmodule

// File: rtl/cs_readout.sv
module cs_readout
   import cs_readout_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int CNT_W    = 8,
   parameter int PF_DEPTH = 2,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_frame,
   output logic              ram_rd_en,
   output logic [ADDR_W-1:0] ram_rd_addr,
   input  logic [CNT_W-1:0]  ram_rd_data,
   output logic              ram_clr_en,
   output logic [ADDR_W-1:0] ram_clr_addr,
   output logic              out_frame,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_data
);

   localparam int OCC_W = occ_width(PF_DEPTH);
   localparam int PTR_W = ptr_width(PF_DEPTH);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("cs_readout: ADDR_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("cs_readout: CNT_W must be at least 1");
   end
   if (PF_DEPTH < 2) begin : g_bad_depth
      $error("cs_readout: PF_DEPTH below 2 cannot stream without gaps");
   end

   seq_state_e        state_q;
   logic              frame_d_q;
   logic              start;
   logic              active;
   logic              pass_end;
   logic [OCC_W-1:0]  occ;
   logic              pop;
   logic              inflight;
   logic [ADDR_W-1:0] inflight_addr;
   logic              all_issued;
   logic [ADDR_W-1:0] head_addr;
   logic [CNT_W-1:0]  head_cnt;

   always_comb begin
      active   = (state_q == SEQ_RUN);
      start    = (state_q == SEQ_IDLE) & frame_d_q & ~in_frame;
      pass_end = active & all_issued & ~inflight & (occ == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         frame_d_q <= 1'b0;
      end else begin
         frame_d_q <= in_frame;
         if (start)         state_q <= SEQ_RUN;
         else if (pass_end) state_q <= SEQ_IDLE;
      end
   end

   cs_readout_fetch #(
      .ADDR_W(ADDR_W), .DEPTH(PF_DEPTH), .OCC_W(OCC_W)
   ) fetch_i (
      .clk(clk), .rst_n(rst_n), .start(start), .active(active),
      .occ(occ), .pop(pop), .rd_en(ram_rd_en), .rd_addr(ram_rd_addr),
      .inflight(inflight), .inflight_addr(inflight_addr),
      .all_issued(all_issued)
   );

   cs_readout_store #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(PF_DEPTH),
      .OCC_W(OCC_W), .PTR_W(PTR_W)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .push(inflight), .push_addr(inflight_addr),
      .push_cnt(ram_rd_data), .pop(pop), .occ(occ),
      .head_addr(head_addr), .head_cnt(head_cnt)
   );

   cs_readout_emit #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)
   ) emit_i (
      .clk(clk), .rst_n(rst_n), .start(start), .head_valid(occ != '0),
      .head_addr(head_addr), .head_cnt(head_cnt), .pass_end(pass_end),
      .pop(pop), .out_valid(out_valid), .out_data(out_data),
      .out_frame(out_frame)
   );

   // zeroing trails the read by the RAM latency
   assign ram_clr_en   = inflight;
   assign ram_clr_addr = inflight_addr;

   // ordering trackers used only by the properties below
   logic [ADDR_W-1:0] chk_rd_q, chk_out_q;
   logic              chk_rd_seen_q, chk_out_seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_rd_q       <= '0;
         chk_out_q      <= '0;
         chk_rd_seen_q  <= 1'b0;
         chk_out_seen_q <= 1'b0;
      end else begin
         if (start) begin
            chk_rd_seen_q  <= 1'b0;
            chk_out_seen_q <= 1'b0;
         end
         if (ram_rd_en) begin
            chk_rd_q      <= ram_rd_addr;
            chk_rd_seen_q <= 1'b1;
         end
         if (out_valid) begin
            chk_out_q      <= out_data;
            chk_out_seen_q <= 1'b1;
         end
      end
   end

   a_r7_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_frame);

   a_r3_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_IDLE) |-> !ram_rd_en);

   a_r3_read_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_rd_en && chk_rd_seen_q) |-> ram_rd_addr == chk_rd_q + 1'b1);

   a_r4_out_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && chk_out_seen_q) |-> out_data >= chk_out_q);

   a_r8_clear_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      ram_rd_en |=> ram_clr_en && ram_clr_addr == $past(ram_rd_addr));

endmodule

// File: tb/cs_readout_tb_top.sv
`timescale 1ns/100ps
module cs_readout_tb_top;

   localparam int AW   = 4;
   localparam int CW   = 3;
   localparam int BINS = 1 << AW;
   localparam int NVEC = 6;

   localparam logic [BINS*CW-1:0] VEC [NVEC] = '{
      48'h249249249249,   // every bin 1
      48'h000000000000,   // empty table
      48'hFFFFFFFFFFFF,   // every bin at maximum
      48'h8C201F4A093B,   // mixed with interior zeros
      48'h000000000007,   // only bin 0, trailing zeros
      48'hE00000000000    // only bin 15, leading zeros
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_frame = 1'b0;
   logic          ram_rd_en, ram_clr_en, out_frame, out_valid;
   logic [AW-1:0] ram_rd_addr, ram_clr_addr, out_data;
   logic [CW-1:0] ram_rd_data;

   always #2.5 clk = ~clk;

   cs_readout #(.ADDR_W(AW), .CNT_W(CW), .PF_DEPTH(2), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_frame(in_frame),
      .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
      .ram_clr_en(ram_clr_en), .ram_clr_addr(ram_clr_addr),
      .out_frame(out_frame), .out_valid(out_valid), .out_data(out_data)
   );

   // count RAM model: one-cycle read, zeroing write port
   logic [CW-1:0] mem [BINS];
   always @(posedge clk) begin
      if (ram_rd_en) ram_rd_data <= mem[ram_rd_addr];
      if (ram_clr_en) mem[ram_clr_addr] <= '0;
   end

   int n_chk = 0, n_fail = 0, cyc = 0;
   int n_got, first_c, last_c, frame_c, rd_c, clr_bad;
   logic [AW-1:0] got [256];
   bit finished = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (out_valid) begin
            if (n_got < 256) got[n_got] = out_data;
            n_got++;
            if (first_c < 0) first_c = cyc;
            last_c = cyc;
         end
         if (out_frame) frame_c++;
         if (ram_rd_en) rd_c++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_got = 0; first_c = -1; last_c = -1; frame_c = 0; rd_c = 0;
   endtask

   task automatic load(input logic [BINS*CW-1:0] v);
      for (int a = 0; a < BINS; a++) mem[a] = v[a*CW +: CW];
   endtask

   task automatic verify(input logic [BINS*CW-1:0] v);
      int total, idx, bad_at, bad_act, bad_exp, nz_bins;
      total = 0; idx = 0; bad_at = -1; bad_act = 0; bad_exp = 0; nz_bins = 0;
      for (int a = 0; a < BINS; a++) begin
         total += int'(v[a*CW +: CW]);
         if (v[a*CW +: CW] != '0) nz_bins++;
         for (int k = 0; k < int'(v[a*CW +: CW]); k++) begin
            if (bad_at < 0 && idx < n_got && int'(got[idx]) != a) begin
               bad_at = idx; bad_act = int'(got[idx]); bad_exp = a;
            end
            idx++;
         end
      end
      check(rd_c == BINS, "R3 reads per pass", rd_c, BINS);
      check(n_got == total, "R4 R5 word count", n_got, total);
      check(bad_at < 0, "R4 sorted word value", bad_act, bad_exp);
      if (nz_bins == BINS)
         check(last_c - first_c + 1 == total, "R6 gap-free span", last_c - first_c + 1, total);
      if (total == 0)
         check(frame_c == 0, "R7 frame stays low", frame_c, 0);
      else if (v[(BINS-1)*CW +: CW] != '0)
         check(frame_c == last_c - first_c + 1, "R7 frame width", frame_c, last_c - first_c + 1);
      clr_bad = 0;
      for (int a = 0; a < BINS; a++) if (mem[a] != '0) clr_bad++;
      check(clr_bad == 0, "R8 table zeroed", clr_bad, 0);
   endtask

   task automatic run_pass(input logic [BINS*CW-1:0] v, input bit glitch);
      load(v);
      clear_mon();
      @(negedge clk) in_frame = 1'b1;
      repeat (3) @(negedge clk);
      in_frame = 1'b0;
      if (glitch) begin
         repeat (12) @(negedge clk);
         in_frame = 1'b1;
         repeat (2) @(negedge clk);
         in_frame = 1'b0;
      end
      repeat (220) @(negedge clk);
      verify(v);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(!out_valid && !out_frame && !ram_rd_en && !ram_clr_en,
            "R1 outputs in reset", int'({out_valid, out_frame, ram_rd_en, ram_clr_en}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && !out_frame && !ram_rd_en,
            "R1 outputs after reset", int'({out_valid, out_frame, ram_rd_en}), 0);

      // vector table
      for (int i = 0; i < NVEC; i++) run_pass(VEC[i], 1'b0);

      // R2: falling edge in the middle of a pass is ignored
      run_pass(48'h5D3A6B1C7E24, 1'b1);

      // R2: rising edge alone starts nothing
      load(48'h492492492492);
      clear_mon();
      @(negedge clk) in_frame = 1'b1;
      repeat (20) @(negedge clk);
      check(rd_c == 0, "R2 no reads on rising edge", rd_c, 0);
      check(n_got == 0, "R2 no words on rising edge", n_got, 0);
      in_frame = 1'b0;
      repeat (220) @(negedge clk);
      verify(48'h492492492492);

      // R5: single bins of one at both ends
      run_pass(48'h200000000001, 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule